// File: doc/BRIEF.md
# Debug Trace and Breakpoint Sequencer

This block runs a single debug session. Once armed, it watches trigger strobes from a set of comparator channels, from a software trigger bit and from an external tag pin. It decides when a trace buffer may store entries, counts the entries that the buffer reports as written, and decides when the session is over. At the end of a session it can raise a breakpoint request towards one or both debug targets.

When the session is armed, the block captures the trace alignment and trace-select settings. The alignment decides where the trigger sits in the captured window. In end alignment the trigger closes the window. In begin alignment the trigger opens the window, which then runs until the buffer is full. In mid alignment the window runs for a fixed number of entries after the trigger. Three paths ignore the alignment. A channel flagged for immediate break ends the session at its trigger. An external tag hit in emulation mode ends the session at once. A software trigger fires the final state even while the block is idle. Target 1 is the CPU. Target 0 is the second bus master.

Top module: `dbg_trace_seq`

## Requirements
- R1: After reset, trace_cap, session_done, brk_req, entry_cnt, trace_full and cfg_err are all zero.
- R2: End alignment (code 2'b00) with tracing selected works as follows. Once armed, trace_cap is high and each entry_wr raises entry_cnt by one. On a trigger, trace_cap drops in the next cycle, session_done pulses, and brk_req equals cfg_brk_en.
- R3: Begin alignment (code 2'b01) works as follows. While the session waits for a trigger, trace_cap is low and entry_wr is not counted. After the trigger, capture runs until entry_cnt reaches DEPTH. In that same cycle session_done pulses, brk_req equals cfg_brk_en, and trace_cap drops.
- R4: Mid alignment (code 2'b10) works as follows. Capture starts at the trigger. The session ends, and brk_req equals cfg_brk_en, in the cycle after the MID_LEN-th entry written after the trigger.
- R5: A trigger on a channel whose cfg_chan_imm bit is set ends the session in the next cycle under every alignment, with brk_req equal to cfg_brk_en.
- R6: With cfg_trace_en low, trace_cap stays low and entries are not counted. Any trigger ends the session at once, with brk_req equal to cfg_brk_en.
- R7: A sw_trig pulse while the block is idle or disarmed causes session_done and brk_req equal to cfg_brk_en in the next cycle.
- R8: A tag_hit is ignored unless cfg_emul is high. With cfg_emul high during an armed session, the session ends in the next cycle, and brk_req is {cfg_brk_en[1], 1'b0}, so only the CPU target can be requested.
- R9: With cfg_brk_en equal to 2'b00, a session still ends with session_done, but brk_req stays zero.
- R10: A session armed with the reserved code 2'b11 captures as in end alignment and never raises brk_req from a trigger. It also sets cfg_err, which stays set until reset.
- R11: A non-zero brk_req lasts one cycle. After a session ends, triggers are ignored until cfg_arm falls and rises again.
- R12: entry_cnt saturates at DEPTH. trace_full is high exactly when entry_cnt equals DEPTH.
- R13: Dropping cfg_arm during a session returns the block to idle in the next cycle, with trace_cap low and without session_done or brk_req.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cfg_align | input | 2 | Trace alignment code: 00 end, 01 begin, 10 mid, 11 reserved |
| cfg_brk_en | input | 2 | Breakpoint enable per target: bit 1 CPU, bit 0 second master |
| cfg_chan_imm | input | NCH | Immediate-break flag for each comparator channel |
| cfg_arm | input | 1 | Arm level; a rising edge starts a session |
| cfg_emul | input | 1 | Emulation mode; enables the external tag path |
| cfg_trace_en | input | 1 | Trace capture selected for the session |
| chan_hit | input | NCH | Final-state trigger strobes from the comparator channels |
| sw_trig | input | 1 | Software trigger-bit strobe |
| tag_hit | input | 1 | External tag hit strobe |
| entry_wr | input | 1 | Trace buffer reports one entry written |
| trace_cap | output | 1 | Trace buffer may store entries |
| session_done | output | 1 | One-cycle pulse when a session ends |
| brk_req | output | 2 | One-cycle breakpoint request per target |
| entry_cnt | output | CW | Entries stored in this session, saturating at DEPTH |
| trace_full | output | 1 | Entry count has reached DEPTH |
| cfg_err | output | 1 | Sticky flag: reserved alignment was armed |

## Verification
The bound checker examines every cycle for the following properties. A breakpoint request lasts a single cycle and always comes with a session-done pulse. It never names a target whose enable was clear in the previous cycle. Capture is off after every session end. The entry count never passes the depth, and the error flag is sticky. The directed scenarios cover what depends on a sequence of events. This includes the exact cycle at which each alignment closes its window and the override by the immediate flag. It also covers the emulation gating of the tag path, the software trigger while disarmed, the need to re-arm, the abort on disarm, and the saturation of the count.

// File: rtl/dbg_seq_pkg.sv
package dbg_seq_pkg;

  typedef enum logic [1:0] {
    ALN_END   = 2'b00,
    ALN_BEGIN = 2'b01,
    ALN_MID   = 2'b10,
    ALN_RSVD  = 2'b11
  } align_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'b00,
    ST_ARMED = 2'b01,
    ST_POST  = 2'b10
  } seq_st_e;

  typedef struct packed {
    logic any;  // some trigger source fired
    logic imm;  // a firing channel carries the immediate-break flag
  } trig_s;

endpackage

// File: rtl/dbg_trig_merge.sv
module dbg_trig_merge
  import dbg_seq_pkg::*;
#(
  parameter int NCH = 4
) (
  input  logic [NCH-1:0] chan_hit,
  input  logic [NCH-1:0] chan_imm,
  input  logic           sw_trig,
  output trig_s          trig
);

  logic [NCH-1:0] imm_vec;

  for (genvar i = 0; i < NCH; i++) begin : g_chan
    assign imm_vec[i] = chan_hit[i] & chan_imm[i];
  end

  always_comb begin
    trig.any = (|chan_hit) | sw_trig;
    trig.imm = |imm_vec;
  end

endmodule

// File: rtl/dbg_entry_cnt.sv
module dbg_entry_cnt #(
  parameter int DEPTH   = 64,
  parameter int MID_LEN = 32,
  localparam int CW = $clog2(DEPTH + 1),
  localparam int PW = $clog2(MID_LEN + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,       // new session
  input  logic          wr_en,     // counted entry write
  input  logic          post_clr,  // trigger opened a post window
  input  logic          post_en,   // entry write inside post window
  output logic [CW-1:0] entry_cnt,
  output logic          full,
  output logic          last_fill, // this write fills the buffer
  output logic          mid_last   // this write closes the mid window
);

  logic [CW-1:0] cnt_q, cnt_d;
  logic [PW-1:0] post_q, post_d;
  logic          cnt_at_top;

  assign cnt_at_top = (cnt_q == CW'(DEPTH));

  always_comb begin
    cnt_d = cnt_q;
    if (clr) begin
      cnt_d = '0;
    end else if (wr_en && !cnt_at_top) begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_comb begin
    post_d = post_q;
    if (post_clr) begin
      post_d = '0;
    end else if (post_en && (post_q != PW'(MID_LEN))) begin
      post_d = post_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      post_q <= '0;
    end else begin
      cnt_q  <= cnt_d;
      post_q <= post_d;
    end
  end

  assign entry_cnt = cnt_q;
  assign full      = cnt_at_top;
  assign last_fill = wr_en && (cnt_q == CW'(DEPTH - 1));
  assign mid_last  = post_en && (post_q == PW'(MID_LEN - 1));

endmodule

// File: rtl/dbg_seq_ctrl.sv
module dbg_seq_ctrl
  import dbg_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cfg_arm,
  input  logic [1:0] cfg_align,
  input  logic       cfg_trace_en,
  input  logic [1:0] cfg_brk_en,
  input  logic       cfg_emul,
  input  trig_s      trig,
  input  logic       sw_trig,
  input  logic       tag_hit,
  input  logic       last_fill,
  input  logic       mid_last,
  output logic       arm_start,
  output logic       post_clr,
  output logic       post_act,
  output logic       trace_cap,
  output logic       session_done,
  output logic [1:0] brk_req,
  output logic       cfg_err
);

  seq_st_e    st_q, st_d;
  align_e     aln_q, aln_d;
  logic       trc_q, trc_d;
  logic       err_q, err_d;
  logic       arm_q;
  logic       done_q, done_d;
  logic [1:0] brk_q, brk_d;
  logic       tag_ok;
  logic       end_style;

  assign arm_start = cfg_arm && !arm_q && (st_q == ST_IDLE);
  assign tag_ok    = tag_hit && cfg_emul;
  assign end_style = (aln_q == ALN_END) || (aln_q == ALN_RSVD);

  always_comb begin
    st_d     = st_q;
    aln_d    = aln_q;
    trc_d    = trc_q;
    err_d    = err_q;
    done_d   = 1'b0;
    brk_d    = 2'b00;
    post_clr = 1'b0;
    case (st_q)
      ST_IDLE: begin
        if (arm_start) begin
          st_d  = ST_ARMED;
          aln_d = align_e'(cfg_align);
          trc_d = cfg_trace_en;
          if (align_e'(cfg_align) == ALN_RSVD) begin
            err_d = 1'b1;
          end
        end else if (sw_trig) begin
          // software trigger forces the final state even while disarmed
          done_d = 1'b1;
          brk_d  = cfg_brk_en;
        end
      end
      ST_ARMED: begin
        if (!cfg_arm) begin
          st_d = ST_IDLE;
        end else if (tag_ok) begin
          st_d   = ST_IDLE;
          done_d = 1'b1;
          brk_d  = {cfg_brk_en[1], 1'b0};
        end else if (trig.any) begin
          if (trig.imm || !trc_q || end_style) begin
            st_d   = ST_IDLE;
            done_d = 1'b1;
            brk_d  = (aln_q == ALN_RSVD) ? 2'b00 : cfg_brk_en;
          end else begin
            st_d     = ST_POST;
            post_clr = 1'b1;
          end
        end
      end
      ST_POST: begin
        if (!cfg_arm) begin
          st_d = ST_IDLE;
        end else if (tag_ok) begin
          st_d   = ST_IDLE;
          done_d = 1'b1;
          brk_d  = {cfg_brk_en[1], 1'b0};
        end else if (((aln_q == ALN_BEGIN) && last_fill) ||
                     ((aln_q == ALN_MID) && mid_last)) begin
          st_d   = ST_IDLE;
          done_d = 1'b1;
          brk_d  = cfg_brk_en;
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      aln_q  <= ALN_END;
      trc_q  <= 1'b0;
      err_q  <= 1'b0;
      arm_q  <= 1'b0;
      done_q <= 1'b0;
      brk_q  <= 2'b00;
    end else begin
      st_q   <= st_d;
      aln_q  <= aln_d;
      trc_q  <= trc_d;
      err_q  <= err_d;
      arm_q  <= cfg_arm;
      done_q <= done_d;
      brk_q  <= brk_d;
    end
  end

  assign post_act     = (st_q == ST_POST);
  assign trace_cap    = ((st_q == ST_ARMED) && trc_q && end_style) || post_act;
  assign session_done = done_q;
  assign brk_req      = brk_q;
  assign cfg_err      = err_q;

endmodule

// File: rtl/dbg_trace_seq.sv
module dbg_trace_seq
  import dbg_seq_pkg::*;
#(
  parameter int NCH     = 4,
  parameter int DEPTH   = 64,
  parameter int MID_LEN = 32,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [1:0]     cfg_align,
  input  logic [1:0]     cfg_brk_en,
  input  logic [NCH-1:0] cfg_chan_imm,
  input  logic           cfg_arm,
  input  logic           cfg_emul,
  input  logic           cfg_trace_en,
  input  logic [NCH-1:0] chan_hit,
  input  logic           sw_trig,
  input  logic           tag_hit,
  input  logic           entry_wr,
  output logic           trace_cap,
  output logic           session_done,
  output logic [1:0]     brk_req,
  output logic [CW-1:0]  entry_cnt,
  output logic           trace_full,
  output logic           cfg_err
);

  logic  [1:0] rst_sync;
  logic        rst_n_i;
  trig_s       trig;
  logic        arm_start, post_clr, post_act;
  logic        last_fill, mid_last;

  // reset asserts at once and leaves two clocks later
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync <= 2'b00;
    end else begin
      rst_sync <= {rst_sync[0], 1'b1};
    end
  end
  assign rst_n_i = rst_sync[1];

  dbg_trig_merge #(.NCH(NCH)) u_merge (
    .chan_hit (chan_hit),
    .chan_imm (cfg_chan_imm),
    .sw_trig  (sw_trig),
    .trig     (trig)
  );

  dbg_seq_ctrl u_ctrl (
    .clk          (clk),
    .rst_n        (rst_n_i),
    .cfg_arm      (cfg_arm),
    .cfg_align    (cfg_align),
    .cfg_trace_en (cfg_trace_en),
    .cfg_brk_en   (cfg_brk_en),
    .cfg_emul     (cfg_emul),
    .trig         (trig),
    .sw_trig      (sw_trig),
    .tag_hit      (tag_hit),
    .last_fill    (last_fill),
    .mid_last     (mid_last),
    .arm_start    (arm_start),
    .post_clr     (post_clr),
    .post_act     (post_act),
    .trace_cap    (trace_cap),
    .session_done (session_done),
    .brk_req      (brk_req),
    .cfg_err      (cfg_err)
  );

  dbg_entry_cnt #(.DEPTH(DEPTH), .MID_LEN(MID_LEN)) u_cnt (
    .clk       (clk),
    .rst_n     (rst_n_i),
    .clr       (arm_start),
    .wr_en     (entry_wr && trace_cap),
    .post_clr  (post_clr),
    .post_en   (entry_wr && post_act),
    .entry_cnt (entry_cnt),
    .full      (trace_full),
    .last_fill (last_fill),
    .mid_last  (mid_last)
  );

endmodule

// File: rtl/dbg_trace_seq_chk.sv
module dbg_trace_seq_chk #(
  parameter int DEPTH = 64,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic [1:0]    cfg_brk_en,
  input logic          trace_cap,
  input logic          session_done,
  input logic [1:0]    brk_req,
  input logic [CW-1:0] entry_cnt,
  input logic          cfg_err
);

  assert_brk_single_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (brk_req != 2'b00) |=> (brk_req == 2'b00));

  assert_brk_ends_session_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (brk_req != 2'b00) |-> session_done);

  assert_brk_enabled_only_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (brk_req != 2'b00) |-> ((brk_req & ~$past(cfg_brk_en)) == 2'b00));

  assert_done_stops_capture_R2: assert property (@(posedge clk) disable iff (!rst_n)
    session_done |-> !trace_cap);

  assert_cnt_bound_R12: assert property (@(posedge clk) disable iff (!rst_n)
    entry_cnt <= CW'(DEPTH));

  assert_err_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_err |=> cfg_err);

endmodule

bind dbg_trace_seq dbg_trace_seq_chk #(.DEPTH(DEPTH)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .cfg_brk_en   (cfg_brk_en),
  .trace_cap    (trace_cap),
  .session_done (session_done),
  .brk_req      (brk_req),
  .entry_cnt    (entry_cnt),
  .cfg_err      (cfg_err)
);

// File: tb/tb_dbg_trace_seq.sv
module tb_dbg_trace_seq;

  localparam int CLK_PERIOD = 10;
  localparam int NCH     = 4;
  localparam int DEPTH   = 64;
  localparam int MID_LEN = 32;
  localparam int CW      = $clog2(DEPTH + 1);

  logic           clk = 1'b0;
  logic           rst_n;
  logic [1:0]     cfg_align;
  logic [1:0]     cfg_brk_en;
  logic [NCH-1:0] cfg_chan_imm;
  logic           cfg_arm, cfg_emul, cfg_trace_en;
  logic [NCH-1:0] chan_hit;
  logic           sw_trig, tag_hit, entry_wr;
  logic           trace_cap, session_done, trace_full, cfg_err;
  logic [1:0]     brk_req;
  logic [CW-1:0]  entry_cnt;

  int n_checks = 0;
  int n_errors = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  dbg_trace_seq #(.NCH(NCH), .DEPTH(DEPTH), .MID_LEN(MID_LEN)) dut (
    .clk, .rst_n, .cfg_align, .cfg_brk_en, .cfg_chan_imm, .cfg_arm, .cfg_emul,
    .cfg_trace_en, .chan_hit, .sw_trig, .tag_hit, .entry_wr, .trace_cap,
    .session_done, .brk_req, .entry_cnt, .trace_full, .cfg_err
  );

  task automatic chk(input string req, input int act, input int exp, input string what);
    n_checks++;
    if (act != exp) begin
      n_errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic arm_session(input logic [1:0] aln, input logic trc, input logic [1:0] brk);
    @(negedge clk);
    cfg_arm = 1'b0; cfg_align = aln; cfg_trace_en = trc; cfg_brk_en = brk;
    @(negedge clk);
    cfg_arm = 1'b1;
    @(negedge clk);
  endtask

  task automatic writes(input int n);
    entry_wr = 1'b1;
    repeat (n) @(negedge clk);
    entry_wr = 1'b0;
  endtask

  task automatic hit(input int ch);
    chan_hit[ch] = 1'b1;
    @(negedge clk);
    chan_hit = '0;
  endtask

  task automatic t_reset;
    chk("R1", int'(trace_cap), 0, "trace_cap");
    chk("R1", int'(session_done), 0, "session_done");
    chk("R1", int'(brk_req), 0, "brk_req");
    chk("R1", int'(entry_cnt), 0, "entry_cnt");
    chk("R1", int'(trace_full), 0, "trace_full");
    chk("R1", int'(cfg_err), 0, "cfg_err");
  endtask

  task automatic t_end;
    arm_session(2'b00, 1'b1, 2'b11);
    chk("R2", int'(trace_cap), 1, "capture before trigger");
    writes(5);
    chk("R2", int'(entry_cnt), 5, "entries counted");
    hit(0);
    chk("R2", int'(session_done), 1, "done on trigger");
    chk("R2", int'(brk_req), 3, "brk on trigger");
    chk("R2", int'(trace_cap), 0, "capture stops");
    @(negedge clk);
    chk("R11", int'(brk_req), 0, "brk single cycle");
    hit(1);
    chk("R11", int'(session_done), 0, "trigger ignored without re-arm");
  endtask

  task automatic t_begin;
    arm_session(2'b01, 1'b1, 2'b01);
    chk("R3", int'(trace_cap), 0, "no capture before trigger");
    writes(3);
    chk("R3", int'(entry_cnt), 0, "pre-trigger writes ignored");
    hit(3);
    chk("R3", int'(trace_cap), 1, "capture after trigger");
    writes(DEPTH - 1);
    chk("R3", int'(session_done), 0, "not done before full");
    chk("R12", int'(trace_full), 0, "not full at DEPTH-1");
    writes(1);
    chk("R3", int'(session_done), 1, "done at full");
    chk("R3", int'(brk_req), 1, "brk at full");
    chk("R12", int'(trace_full), 1, "full flag");
    chk("R12", int'(entry_cnt), DEPTH, "count at full");
    chk("R3", int'(trace_cap), 0, "capture stops at full");
  endtask

  task automatic t_mid;
    arm_session(2'b10, 1'b1, 2'b10);
    hit(0);
    writes(MID_LEN - 1);
    chk("R4", int'(session_done), 0, "not done before window end");
    chk("R4", int'(trace_cap), 1, "still capturing");
    writes(1);
    chk("R4", int'(session_done), 1, "done after window");
    chk("R4", int'(brk_req), 2, "brk after window");
    chk("R4", int'(entry_cnt), MID_LEN, "entries in window");
  endtask

  task automatic t_imm;
    cfg_chan_imm = 4'b0100;
    arm_session(2'b01, 1'b1, 2'b11);
    hit(2);
    chk("R5", int'(session_done), 1, "immediate end begin mode");
    chk("R5", int'(brk_req), 3, "immediate brk");
    chk("R5", int'(trace_cap), 0, "capture off");
    arm_session(2'b10, 1'b1, 2'b00);
    hit(2);
    chk("R5", int'(session_done), 1, "immediate end mid mode");
    chk("R9", int'(brk_req), 0, "no brk when disabled");
    cfg_chan_imm = '0;
  endtask

  task automatic t_notrace;
    arm_session(2'b00, 1'b0, 2'b01);
    chk("R6", int'(trace_cap), 0, "no capture without trace");
    writes(4);
    chk("R6", int'(entry_cnt), 0, "no count without trace");
    hit(1);
    chk("R6", int'(session_done), 1, "immediate end");
    chk("R6", int'(brk_req), 1, "immediate brk");
  endtask

  task automatic t_sw_idle;
    @(negedge clk);
    cfg_arm = 1'b0; cfg_brk_en = 2'b10;
    sw_trig = 1'b1;
    @(negedge clk);
    sw_trig = 1'b0;
    chk("R7", int'(session_done), 1, "sw trigger while disarmed");
    chk("R7", int'(brk_req), 2, "sw trigger brk");
  endtask

  task automatic t_tag;
    cfg_emul = 1'b0;
    arm_session(2'b00, 1'b1, 2'b11);
    tag_hit = 1'b1;
    @(negedge clk);
    tag_hit = 1'b0;
    chk("R8", int'(session_done), 0, "tag ignored outside emulation");
    chk("R8", int'(trace_cap), 1, "session still running");
    cfg_emul = 1'b1;
    tag_hit = 1'b1;
    @(negedge clk);
    tag_hit = 1'b0;
    chk("R8", int'(session_done), 1, "tag ends session");
    chk("R8", int'(brk_req), 2, "tag brk to CPU only");
    cfg_emul = 1'b0;
  endtask

  task automatic t_nobrk;
    arm_session(2'b00, 1'b1, 2'b00);
    hit(0);
    chk("R9", int'(session_done), 1, "done with brk off");
    chk("R9", int'(brk_req), 0, "no brk with enable clear");
  endtask

  task automatic t_rsvd;
    arm_session(2'b11, 1'b1, 2'b11);
    chk("R10", int'(cfg_err), 1, "error flag on reserved");
    chk("R10", int'(trace_cap), 1, "reserved captures like end");
    writes(DEPTH + 6);
    chk("R12", int'(entry_cnt), DEPTH, "count saturates");
    chk("R12", int'(trace_full), 1, "full while saturated");
    hit(1);
    chk("R10", int'(session_done), 1, "reserved ends on trigger");
    chk("R10", int'(brk_req), 0, "reserved never breaks");
    arm_session(2'b00, 1'b1, 2'b00);
    chk("R10", int'(cfg_err), 1, "error flag sticky");
    chk("R12", int'(entry_cnt), 0, "count cleared on arm");
  endtask

  task automatic t_abort;
    arm_session(2'b01, 1'b1, 2'b11);
    hit(0);
    chk("R13", int'(trace_cap), 1, "in post window");
    cfg_arm = 1'b0;
    @(negedge clk);
    chk("R13", int'(trace_cap), 0, "abort stops capture");
    chk("R13", int'(session_done), 0, "abort without done");
    chk("R13", int'(brk_req), 0, "abort without brk");
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_checks++;
    n_errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    cfg_align = 2'b00; cfg_brk_en = 2'b00; cfg_chan_imm = '0;
    cfg_arm = 1'b0; cfg_emul = 1'b0; cfg_trace_en = 1'b0;
    chan_hit = '0; sw_trig = 1'b0; tag_hit = 1'b0; entry_wr = 1'b0;
    repeat (3) @(negedge clk);
    t_reset;
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset;
    t_end;
    t_begin;
    t_mid;
    t_imm;
    t_notrace;
    t_sw_idle;
    t_tag;
    t_nobrk;
    t_rsvd;
    t_abort;
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

endmodule